// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block steers a processor into its exception handler. A one-cycle request carries a 5-bit cause code, the PC of the faulting instruction, the PC that was due to follow it, the faulting virtual address, a coprocessor number and a flag that marks a translation-refill miss. On the next clock edge the block updates its exception state: the exception-level and bootstrap bits, the recorded cause, the return PC, the bad address and the shadow-register-set selectors. In the same edge it raises a one-cycle fetch redirect that carries three sequential handler PCs.

The handler address depends on the mode. In bootstrap mode every entry goes to a fixed boot address. A refill miss that is taken while no exception is already being handled uses the base of the vector area. An interrupt uses a separate offset when the dedicated interrupt vector is enabled. Every other entry uses the general offset. A small write port lets a test or boot sequence preset the mode bits and the selectors. The exception-return path is not part of this block.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After any request, `st_exl` reads 1 on the next edge, whether it was 0 or 1 before.
- R2: When `exc_pc + 4 != exc_npc`, the fault is taken as a delay-slot fault: `epc` becomes `exc_pc - 4` and `cause_bd` becomes 1. Otherwise `epc` becomes `exc_pc` and `cause_bd` becomes 0.
- R3: `cause_code` takes `exc_code`. `cause_ce` takes `exc_cpid` only for code 11 (coprocessor unusable) and is cleared for every other code.
- R4: Codes 1 to 5 (translation modified, translation fault on fetch/load, translation fault on store, address error on load, address error on store) load `exc_badva` into `badvaddr`. Codes 0, 8, 9, 10, 11, 12 and 13 leave `badvaddr` unchanged.
- R5: With `st_bev` at 0, a request with `exc_refill` set goes to `ebase + 0x000` if `st_exl` was 0 before the request. If `st_exl` was already 1 it goes to `ebase + 0x180`.
- R6: With `st_bev` at 0 and no refill, code 0 (interrupt) with `cause_iv` at 1 goes to `ebase + 0x200`. Every other case goes to `ebase + 0x180`.
- R7: With `st_bev` at 1, every request goes to the fixed address 0xBFC00200.
- R8: Only when `st_exl` and `st_bev` are both 0 before a request, `srs_prev` takes the old `srs_cur` and `srs_cur` takes `srs_ent`. In every other case both stay unchanged.
- R9: `redirect_valid` is 1 for exactly the one cycle after a request. While it is 1, `fetch_pc`, `fetch_npc` and `fetch_nnpc` hold the handler base, base + 4 and base + 8.
- R10: While `rst` is high, `st_bev` = 1, `st_exl` = 0, `ebase` = 0x80000000, `redirect_valid` = 1 and the fetch triple is 0xBFC00000, 0xBFC00004, 0xBFC00008.
- R11: A setup write takes effect when `cfg_we` is 1 and no request is present. The `cfg_sel` values select the target:
  - 0 sets status, with EXL in bit 0 and BEV in bit 1.
  - 1 sets `cause_iv` from bit 0.
  - 2 loads `ebase`.
  - 3 loads the selectors: `srs_ent` from bits 3:0, `srs_cur` from bits 7:4 and `srs_prev` from bits 11:8.

  If a request and a write arrive in the same cycle, the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | One-cycle exception request |
| exc_code | input | 5 | Cause code of the request |
| exc_refill | input | 1 | Request is a translation-refill miss |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_npc | input | 32 | PC that was due to follow it |
| exc_badva | input | 32 | Faulting virtual address |
| exc_cpid | input | 2 | Coprocessor number for code 11 |
| cfg_we | input | 1 | Setup write enable |
| cfg_sel | input | 2 | Setup write target |
| cfg_wdata | input | 32 | Setup write data |
| st_exl | output | 1 | Exception level bit |
| st_bev | output | 1 | Bootstrap vector bit |
| cause_code | output | 5 | Recorded cause code |
| cause_bd | output | 1 | Fault was in a delay slot |
| cause_ce | output | 2 | Recorded coprocessor number |
| cause_iv | output | 1 | Dedicated interrupt vector enabled |
| epc | output | 32 | Return PC |
| badvaddr | output | 32 | Recorded faulting address |
| ebase | output | 32 | Base of the vector area |
| srs_cur | output | 4 | Active shadow set |
| srs_prev | output | 4 | Previous shadow set |
| srs_ent | output | 4 | Shadow set to use on exception entry |
| redirect_valid | output | 1 | Fetch redirect strobe |
| fetch_pc | output | 32 | Handler PC |
| fetch_npc | output | 32 | Handler PC + 4 |
| fetch_nnpc | output | 32 | Handler PC + 8 |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 4-bit shadow-set index and a 2-bit coprocessor number. These widths keep every sweep small. The bench runs every defined cause code against every combination of the EXL, BEV and interrupt-vector bits, delay-slot placement and, for the two translation codes, the refill flag. This covers all four handler-address choices, both shadow-set outcomes and both return-PC forms. It also varies the vector base and the selector values from case to case, so a wrong field mapping shows up as a wrong value.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int unsigned CODE_W = 5;

    typedef enum logic [CODE_W-1:0] {
        EXC_INT     = 5'd0,
        EXC_TLB_MOD = 5'd1,
        EXC_TLB_LD  = 5'd2,
        EXC_TLB_ST  = 5'd3,
        EXC_ADDR_LD = 5'd4,
        EXC_ADDR_ST = 5'd5,
        EXC_SYSCALL = 5'd8,
        EXC_BREAK   = 5'd9,
        EXC_RESV    = 5'd10,
        EXC_CPU     = 5'd11,
        EXC_OVF     = 5'd12,
        EXC_TRAP    = 5'd13
    } exc_code_e;

    typedef enum logic [1:0] {
        CFG_STATUS = 2'd0,
        CFG_CAUSE  = 2'd1,
        CFG_EBASE  = 2'd2,
        CFG_SHADOW = 2'd3
    } cfg_sel_e;

    // Address-carrying causes: translation and alignment faults
    function automatic logic records_badva(input logic [CODE_W-1:0] c);
        return (c >= EXC_TLB_MOD) && (c <= EXC_ADDR_ST);
    endfunction
endpackage

// File: rtl/exc_slot_detect.sv
module exc_slot_detect #(
    parameter int AW         = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] npc,
    output logic          in_slot,
    output logic [AW-1:0] ret_pc
);
    localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

    // A non-sequential successor means the faulting slot follows a branch
    always_comb begin
        in_slot = (pc + STEP) != npc;
        ret_pc  = in_slot ? (pc - STEP) : pc;
    end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel #(
    parameter int            AW           = 32,
    parameter logic [AW-1:0] BOOT_GEN_VEC = 32'hBFC0_0200,
    parameter logic [AW-1:0] OFS_REFILL   = 32'h0000_0000,
    parameter logic [AW-1:0] OFS_GENERAL  = 32'h0000_0180,
    parameter logic [AW-1:0] OFS_INTR     = 32'h0000_0200
) (
    input  logic [AW-1:0] vec_base,
    input  logic          bev,
    input  logic          exl_before,
    input  logic          iv,
    input  logic          refill,
    input  logic          is_intr,
    output logic [AW-1:0] handler
);
    always_comb begin
        if (bev)
            handler = BOOT_GEN_VEC;
        else if (refill && !exl_before)
            handler = vec_base + OFS_REFILL;
        else if (is_intr && iv)
            handler = vec_base + OFS_INTR;
        else
            handler = vec_base + OFS_GENERAL;
    end
endmodule

// File: rtl/exc_shadow_rotate.sv
module exc_shadow_rotate #(
    parameter int SET_W = 4
) (
    input  logic             rotate,
    input  logic [SET_W-1:0] cur,
    input  logic [SET_W-1:0] prev,
    input  logic [SET_W-1:0] ent,
    output logic [SET_W-1:0] cur_n,
    output logic [SET_W-1:0] prev_n
);
    always_comb begin
        cur_n  = rotate ? ent : cur;
        prev_n = rotate ? cur : prev;
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int            AW           = 32,
    parameter int            CP_W         = 2,
    parameter int            SET_W        = 4,
    parameter int            INSN_BYTES   = 4,
    parameter logic [AW-1:0] RESET_VEC    = 32'hBFC0_0000,
    parameter logic [AW-1:0] BOOT_GEN_VEC = 32'hBFC0_0200,
    parameter logic [AW-1:0] EBASE_INIT   = 32'h8000_0000,
    parameter logic [AW-1:0] OFS_REFILL   = 32'h0000_0000,
    parameter logic [AW-1:0] OFS_GENERAL  = 32'h0000_0180,
    parameter logic [AW-1:0] OFS_INTR     = 32'h0000_0200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              exc_refill,
    input  logic [AW-1:0]     exc_pc,
    input  logic [AW-1:0]     exc_npc,
    input  logic [AW-1:0]     exc_badva,
    input  logic [CP_W-1:0]   exc_cpid,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [AW-1:0]     cfg_wdata,
    output logic              st_exl,
    output logic              st_bev,
    output logic [CODE_W-1:0] cause_code,
    output logic              cause_bd,
    output logic [CP_W-1:0]   cause_ce,
    output logic              cause_iv,
    output logic [AW-1:0]     epc,
    output logic [AW-1:0]     badvaddr,
    output logic [AW-1:0]     ebase,
    output logic [SET_W-1:0]  srs_cur,
    output logic [SET_W-1:0]  srs_prev,
    output logic [SET_W-1:0]  srs_ent,
    output logic              redirect_valid,
    output logic [AW-1:0]     fetch_pc,
    output logic [AW-1:0]     fetch_npc,
    output logic [AW-1:0]     fetch_nnpc
);
    localparam int TRIP_N = 3;

    typedef struct packed {
        logic              exl;
        logic              bev;
        logic [CODE_W-1:0] code;
        logic              bd;
        logic [CP_W-1:0]   ce;
        logic              iv;
        logic [AW-1:0]     epc;
        logic [AW-1:0]     badva;
        logic [AW-1:0]     ebase;
        logic [SET_W-1:0]  cur;
        logic [SET_W-1:0]  prev;
        logic [SET_W-1:0]  ent;
        logic              redir;
        logic [AW-1:0]     pc0;
        logic [AW-1:0]     pc1;
        logic [AW-1:0]     pc2;
    } state_t;

    state_t st_d, st_q;

    logic          slot_hit;
    logic [AW-1:0] slot_ret;
    logic [AW-1:0] vec_addr;
    logic          rot_en;
    logic [SET_W-1:0] cur_rot, prev_rot;
    logic [AW-1:0] trip [TRIP_N];

    exc_slot_detect #(.AW(AW), .INSN_BYTES(INSN_BYTES)) u_slot (
        .pc      (exc_pc),
        .npc     (exc_npc),
        .in_slot (slot_hit),
        .ret_pc  (slot_ret)
    );

    exc_vector_sel #(
        .AW(AW), .BOOT_GEN_VEC(BOOT_GEN_VEC), .OFS_REFILL(OFS_REFILL),
        .OFS_GENERAL(OFS_GENERAL), .OFS_INTR(OFS_INTR)
    ) u_vec (
        .vec_base   (st_q.ebase),
        .bev        (st_q.bev),
        .exl_before (st_q.exl),
        .iv         (st_q.iv),
        .refill     (exc_refill),
        .is_intr    (exc_code == EXC_INT),
        .handler    (vec_addr)
    );

    assign rot_en = exc_valid && !st_q.exl && !st_q.bev;

    exc_shadow_rotate #(.SET_W(SET_W)) u_srs (
        .rotate (rot_en),
        .cur    (st_q.cur),
        .prev   (st_q.prev),
        .ent    (st_q.ent),
        .cur_n  (cur_rot),
        .prev_n (prev_rot)
    );

    for (genvar k = 0; k < TRIP_N; k++) begin : g_trip
        assign trip[k] = vec_addr + AW'(k * INSN_BYTES);
    end

    always_comb begin
        st_d       = st_q;
        st_d.redir = 1'b0;
        if (exc_valid) begin
            st_d.exl   = 1'b1;
            st_d.code  = exc_code;
            st_d.bd    = slot_hit;
            st_d.epc   = slot_ret;
            st_d.ce    = (exc_code == EXC_CPU) ? exc_cpid : '0;
            if (records_badva(exc_code))
                st_d.badva = exc_badva;
            st_d.cur   = cur_rot;
            st_d.prev  = prev_rot;
            st_d.redir = 1'b1;
            st_d.pc0   = trip[0];
            st_d.pc1   = trip[1];
            st_d.pc2   = trip[2];
        end else if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                CFG_STATUS: begin
                    st_d.exl = cfg_wdata[0];
                    st_d.bev = cfg_wdata[1];
                end
                CFG_CAUSE:  st_d.iv    = cfg_wdata[0];
                CFG_EBASE:  st_d.ebase = cfg_wdata;
                CFG_SHADOW: begin
                    st_d.ent  = cfg_wdata[SET_W-1:0];
                    st_d.cur  = cfg_wdata[2*SET_W-1:SET_W];
                    st_d.prev = cfg_wdata[3*SET_W-1:2*SET_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.bev   <= 1'b1;
            st_q.ebase <= EBASE_INIT;
            st_q.redir <= 1'b1;
            st_q.pc0   <= RESET_VEC;
            st_q.pc1   <= RESET_VEC + AW'(INSN_BYTES);
            st_q.pc2   <= RESET_VEC + AW'(2 * INSN_BYTES);
        end else begin
            st_q <= st_d;
        end
    end

    assign st_exl         = st_q.exl;
    assign st_bev         = st_q.bev;
    assign cause_code     = st_q.code;
    assign cause_bd       = st_q.bd;
    assign cause_ce       = st_q.ce;
    assign cause_iv       = st_q.iv;
    assign epc            = st_q.epc;
    assign badvaddr       = st_q.badva;
    assign ebase          = st_q.ebase;
    assign srs_cur        = st_q.cur;
    assign srs_prev       = st_q.prev;
    assign srs_ent        = st_q.ent;
    assign redirect_valid = st_q.redir;
    assign fetch_pc       = st_q.pc0;
    assign fetch_npc      = st_q.pc1;
    assign fetch_nnpc     = st_q.pc2;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int            AW           = 32,
    parameter int            CP_W         = 2,
    parameter int            SET_W        = 4,
    parameter int            INSN_BYTES   = 4,
    parameter logic [AW-1:0] BOOT_GEN_VEC = 32'hBFC0_0200
) (
    input logic             clk,
    input logic             rst,
    input logic             exc_valid,
    input logic [4:0]       exc_code,
    input logic [AW-1:0]    exc_pc,
    input logic [AW-1:0]    exc_npc,
    input logic             st_exl,
    input logic             st_bev,
    input logic             cause_bd,
    input logic [CP_W-1:0]  cause_ce,
    input logic [AW-1:0]    epc,
    input logic [AW-1:0]    badvaddr,
    input logic [SET_W-1:0] srs_cur,
    input logic [SET_W-1:0] srs_prev,
    input logic             redirect_valid,
    input logic [AW-1:0]    fetch_pc,
    input logic [AW-1:0]    fetch_npc,
    input logic [AW-1:0]    fetch_nnpc
);
    localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

    AST_EXL_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> st_exl); // R1

    AST_SLOT_EPC: assert property (@(posedge clk) disable iff (rst)
        exc_valid && (exc_pc + STEP != exc_npc)
        |=> cause_bd && (epc == $past(exc_pc) - STEP)); // R2

    AST_SEQ_EPC: assert property (@(posedge clk) disable iff (rst)
        exc_valid && (exc_pc + STEP == exc_npc)
        |=> !cause_bd && (epc == $past(exc_pc))); // R2

    AST_CE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        exc_valid && (exc_code != 5'd11) |=> cause_ce == '0); // R3

    AST_BADVA_KEEP: assert property (@(posedge clk) disable iff (rst)
        exc_valid && (exc_code inside {5'd8, 5'd9, 5'd12, 5'd13})
        |=> $stable(badvaddr)); // R4

    AST_BOOT_VECTOR: assert property (@(posedge clk) disable iff (rst)
        exc_valid && st_bev |=> fetch_pc == BOOT_GEN_VEC); // R7

    AST_SRS_HOLD: assert property (@(posedge clk) disable iff (rst)
        exc_valid && (st_exl || st_bev)
        |=> $stable(srs_cur) && $stable(srs_prev)); // R8

    AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> redirect_valid); // R9

    AST_NO_STRAY_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        !exc_valid |=> !redirect_valid); // R9

    AST_TRIPLE_STEP: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> (fetch_npc == fetch_pc + STEP)
                        && (fetch_nnpc == fetch_pc + 2 * STEP)); // R9
endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .AW(AW), .CP_W(CP_W), .SET_W(SET_W), .INSN_BYTES(INSN_BYTES),
    .BOOT_GEN_VEC(BOOT_GEN_VEC)
) u_chk (.*);

// File: tb/sim_exc_entry_ctrl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exc_valid = 1'b0;
    logic [4:0]  exc_code = '0;
    logic        exc_refill = 1'b0;
    logic [31:0] exc_pc = '0, exc_npc = '0, exc_badva = '0;
    logic [1:0]  exc_cpid = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        st_exl, st_bev, cause_bd, cause_iv, redirect_valid;
    logic [4:0]  cause_code;
    logic [1:0]  cause_ce;
    logic [31:0] epc, badvaddr, ebase, fetch_pc, fetch_npc, fetch_nnpc;
    logic [3:0]  srs_cur, srs_prev, srs_ent;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    exc_entry_ctrl u0 (
        .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_code(exc_code),
        .exc_refill(exc_refill), .exc_pc(exc_pc), .exc_npc(exc_npc),
        .exc_badva(exc_badva), .exc_cpid(exc_cpid), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .st_exl(st_exl),
        .st_bev(st_bev), .cause_code(cause_code), .cause_bd(cause_bd),
        .cause_ce(cause_ce), .cause_iv(cause_iv), .epc(epc),
        .badvaddr(badvaddr), .ebase(ebase), .srs_cur(srs_cur),
        .srs_prev(srs_prev), .srs_ent(srs_ent),
        .redirect_valid(redirect_valid), .fetch_pc(fetch_pc),
        .fetch_npc(fetch_npc), .fetch_nnpc(fetch_nnpc)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R9: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int codes [12] = '{0, 1, 2, 3, 4, 5, 8, 9, 10, 11, 12, 13};
        logic [31:0] bv_model;
        int n;
        n = 0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 bev", st_bev, 1);
        check("R10 exl", st_exl, 0);
        check("R10 ebase", ebase, 32'h8000_0000);
        check("R10 redirect", redirect_valid, 1);
        check("R10 pc", fetch_pc, 32'hBFC0_0000);
        check("R10 npc", fetch_npc, 32'hBFC0_0004);
        check("R10 nnpc", fetch_nnpc, 32'hBFC0_0008);
        rst = 1'b0;
        @(negedge clk);
        check("R9 idle after reset", redirect_valid, 0);
        bv_model = badvaddr;

        for (int ci = 0; ci < 12; ci++) begin
            for (int m = 0; m < 32; m++) begin
                logic exl, bev, iv, ds, rf;
                logic [4:0] code;
                logic [31:0] eb, pc, npc, base, exp_epc;
                logic [3:0] es, cs, ps;
                logic [1:0] cp;
                string tg;
                exl = m[0]; bev = m[1]; iv = m[2]; ds = m[3]; rf = m[4];
                code = 5'(codes[ci]);
                if (rf && !(code == 5'd2 || code == 5'd3)) continue;
                n++;
                eb = 32'h8000_0000 + 32'((n % 4) * 32'h1000);
                es = 4'(n % 16); cs = 4'((n + 5) % 16); ps = 4'((n + 11) % 16);
                cp = 2'(n % 4);
                cfg_write(2'd2, eb);
                cfg_write(2'd1, {31'b0, iv});
                cfg_write(2'd3, {20'b0, ps, cs, es});
                cfg_write(2'd0, {30'b0, bev, exl});
                check("R11 status write", {bev, exl}, {st_bev, st_exl});
                check("R11 shadow write", {ps, cs, es}, {srs_prev, srs_cur, srs_ent});

                pc  = 32'h0040_0000 + 32'(n * 16);
                npc = ds ? pc + 32'h100 : pc + 4;
                exp_epc = ds ? pc - 4 : pc;
                if (bev) begin base = 32'hBFC0_0200; tg = "R7 handler"; end
                else if (rf && !exl) begin base = eb; tg = "R5 handler"; end
                else if (rf) begin base = eb + 32'h180; tg = "R5 handler"; end
                else if (code == 0 && iv) begin base = eb + 32'h200; tg = "R6 handler"; end
                else begin base = eb + 32'h180; tg = "R6 handler"; end
                if (code >= 1 && code <= 5) bv_model = 32'hDEAD_0000 + 32'(n);

                exc_valid = 1'b1; exc_code = code; exc_refill = rf;
                exc_pc = pc; exc_npc = npc; exc_cpid = cp;
                exc_badva = 32'hDEAD_0000 + 32'(n);
                @(negedge clk);
                exc_valid = 1'b0; exc_refill = 1'b0;
                check("R1 exl", st_exl, 1);
                check("R2 epc", epc, exp_epc);
                check("R2 bd", cause_bd, ds);
                check("R3 code", cause_code, code);
                check("R3 ce", cause_ce, (code == 5'd11) ? cp : 2'd0);
                check("R4 badvaddr", badvaddr, bv_model);
                check(tg, fetch_pc, base);
                check("R9 npc", fetch_npc, base + 4);
                check("R9 nnpc", fetch_nnpc, base + 8);
                check("R9 redirect", redirect_valid, 1);
                check("R8 cur", srs_cur, (!exl && !bev) ? es : cs);
                check("R8 prev", srs_prev, (!exl && !bev) ? cs : ps);
                @(negedge clk);
                check("R9 single pulse", redirect_valid, 0);
            end
        end

        // R11 collision: write dropped when a request is present
        cfg_write(2'd0, 32'd0);
        exc_valid = 1'b1; exc_code = 5'd8; exc_pc = 32'h100; exc_npc = 32'h104;
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'd2;
        @(negedge clk);
        exc_valid = 1'b0; cfg_we = 1'b0;
        check("R11 collision bev", st_bev, 0);
        check("R1 collision exl", st_exl, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule